// File: doc/BRIEF.md
# Tagged-Shifter UART Transmitter

This block turns bytes handed over by a CPU into asynchronous serial frames. A byte is placed on the data input and latched when the active-low write strobe returns high. The block then sends one frame: a low start bit, the eight data bits least significant first, one parity bit and a high stop bit. The master clock runs at sixteen times the baud rate, and a four-bit divider derives the bit tick from it.

The shift register carries two extra marker bits above the data byte. Zeros fill it from the top as it shifts, so the position of the markers alone tells the control logic whether a data bit, the parity bit or the stop bit is due. No bit counter is needed. A ready output tells the CPU when the holding register is free. The parity sense is chosen by a mode input.

Top module: `uart_tag_tx`

## Requirements
- R1: While reset is asserted and right after it, tx_o is high and tx_ready_o is high.
- R2: Every bit of a frame holds tx_o steady for exactly 16 master-clock cycles, and tx_o changes only on a bit tick.
- R3: A rising edge on wr_ni captures data_i, and tx_ready_o goes low within 4 master-clock cycles of that edge.
- R4: When no frame is in flight and a byte is pending, the next bit tick drives the start bit (tx_o low) and raises tx_ready_o on the same clock edge.
- R5: The eight data bits follow the start bit, least significant bit first.
- R6: The bit after the data bit 7 is parity. With odd_par_i = 1 the data bits and the parity bit together hold an odd number of ones. With odd_par_i = 0 they hold an even number. odd_par_i is held steady from the write until the parity bit has been sent.
- R7: The stop bit is high, and tx_o stays high while nothing is pending.
- R8: A byte written while a frame is in flight starts exactly one stop-bit time (16 cycles) after the stop bit begins, with no extra idle time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock, 16x baud rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_ni | input | 1 | Write strobe, active low; byte latched on its rising edge |
| data_i | input | 8 | Byte to send |
| odd_par_i | input | 1 | Parity sense: 1 odd, 0 even |
| tx_o | output | 1 | Serial output, high when idle |
| tx_ready_o | output | 1 | High when the holding register can take a byte |

## Verification
If the marker bits get lost or duplicated in the shift register, the frame length changes. The stop bit would then arrive early or late, and this shows on tx_o within one frame (at most 176 cycles). A wrong parity seed or accumulator flips only the tenth bit cell. Checking that cell for both parity modes, with all-zero, all-one and mixed bytes, catches it. A divider or tick fault changes the cell width, so the bench compares every master-clock sample of each frame against the expected bit, not just the centres. A fault in the pending flag shows up either on tx_ready_o within a few cycles of a write, or as a missing or late back-to-back start.

// File: rtl/uart_tag_tx_pkg.sv
package uart_tag_tx_pkg;
  typedef enum logic [1:0] {
    SH_IDLE   = 2'd0,
    SH_DATA   = 2'd1,
    SH_PARITY = 2'd2,
    SH_STOP   = 2'd3
  } sh_kind_e;
endpackage

// File: rtl/uart_tag_tx_baud.sv
module uart_tag_tx_baud #(
  parameter int DIV = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CW = $clog2(DIV);
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);

  // R2: ticks never adjacent
  a_r2_tick_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/uart_tag_tx_wrcap.sv
module uart_tag_tx_wrcap #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              load_i,
  output logic [DATA_W-1:0] hold_o,
  output logic              pending_o
);
  localparam int SW = SYNC_STAGES + 1;

  logic [SW-1:0] sync_q;
  logic          wr_rise;

  // synchronizer stages plus one history bit for edge detect
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SW-2:0], wr_ni};
  end

  assign wr_rise = sync_q[SW-2] & ~sync_q[SW-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_o    <= '0;
      pending_o <= 1'b0;
    end else begin
      if (wr_rise) hold_o <= data_i;
      if (wr_rise)     pending_o <= 1'b1;
      else if (load_i) pending_o <= 1'b0;
    end
  end

  a_r3_rise_sets_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_rise |=> pending_o);
  a_r4_load_frees_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !wr_rise) |=> !pending_o);
endmodule

// File: rtl/uart_tag_tx_shift.sv
module uart_tag_tx_shift
  import uart_tag_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              pending_i,
  input  logic [DATA_W-1:0] hold_i,
  input  logic              odd_par_i,
  output logic              load_o,
  output logic              tx_o
);
  localparam int SH_W = DATA_W + 2;
  localparam logic [SH_W-1:0] STOP_PAT   = SH_W'(1);
  localparam logic [SH_W-1:0] PARITY_PAT = SH_W'(3);

  logic [SH_W-1:0] sh_q;
  logic            par_q;
  sh_kind_e        kind;

  // marker position decides the bit in flight
  always_comb begin
    if (sh_q == '0)              kind = SH_IDLE;
    else if (sh_q == STOP_PAT)   kind = SH_STOP;
    else if (sh_q == PARITY_PAT) kind = SH_PARITY;
    else                         kind = SH_DATA;
  end

  assign load_o = tick_i && (kind == SH_IDLE) && pending_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      par_q <= 1'b0;
      tx_o  <= 1'b1;
    end else if (tick_i) begin
      unique case (kind)
        SH_IDLE: begin
          if (pending_i) begin
            sh_q  <= {2'b11, hold_i};
            par_q <= odd_par_i;
            tx_o  <= 1'b0;
          end else begin
            tx_o  <= 1'b1;
          end
        end
        SH_DATA: begin
          tx_o  <= sh_q[0];
          par_q <= par_q ^ sh_q[0];
          sh_q  <= sh_q >> 1;
        end
        SH_PARITY: begin
          tx_o <= par_q;
          sh_q <= sh_q >> 1;
        end
        SH_STOP: begin
          tx_o <= 1'b1;
          sh_q <= sh_q >> 1;
        end
        default: sh_q <= '0;
      endcase
    end
  end

  a_r4_start_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> !tx_o);
  a_r2_hold_between_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(tx_o));
  a_r7_stop_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && kind == SH_STOP) |=> tx_o);
  a_r7_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && kind == SH_IDLE && !pending_i) |=> tx_o);
endmodule

// File: rtl/uart_tag_tx.sv
module uart_tag_tx #(
  parameter int DATA_W      = 8,
  parameter int DIV         = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ni,
  input  logic [DATA_W-1:0] data_i,
  input  logic              odd_par_i,
  output logic              tx_o,
  output logic              tx_ready_o
);
  logic              tick;
  logic              load;
  logic              pending;
  logic [DATA_W-1:0] hold;

  uart_tag_tx_baud #(.DIV(DIV)) u_baud (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_o(tick)
  );

  uart_tag_tx_wrcap #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_wrcap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_ni    (wr_ni),
    .data_i   (data_i),
    .load_i   (load),
    .hold_o   (hold),
    .pending_o(pending)
  );

  uart_tag_tx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick),
    .pending_i(pending),
    .hold_i   (hold),
    .odd_par_i(odd_par_i),
    .load_o   (load),
    .tx_o     (tx_o)
  );

  assign tx_ready_o = ~pending;
endmodule

// File: tb/uart_tag_tx_test.sv
module uart_tag_tx_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_ni = 1'b1;
  logic [7:0] data_i = '0;
  logic       odd_par_i = 1'b0;
  logic       tx_o;
  logic       tx_ready_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  uart_tag_tx uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_ni(wr_ni), .data_i(data_i),
    .odd_par_i(odd_par_i), .tx_o(tx_o), .tx_ready_o(tx_ready_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  // R3: strobe low, release, ready must fall within 4 cycles
  task automatic wr_byte(input logic [7:0] b);
    int n;
    @(negedge clk);
    data_i = b;
    wr_ni  = 1'b0;
    repeat (3) @(negedge clk);
    wr_ni = 1'b1;
    n = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (!tx_ready_o && n == 0) n = i + 1;
    end
    chk(n != 0, "R3", "ready low after write", int'(tx_ready_o), 0);
    repeat (6) @(negedge clk);
  endtask

  // walks 176 samples of one frame; each cell must be uniform (R2)
  task automatic rx_frame(input logic [7:0] b, input bit odd);
    logic [10:0] exp_bits;
    int wait_n;
    bit cell_ok;
    bit p;
    p = (^b) ^ odd;
    exp_bits = {1'b1, p, b, 1'b0};
    wait_n = 0;
    while (tx_o && wait_n < 400) begin
      @(negedge clk);
      wait_n++;
    end
    chk(!tx_o, "R4", "start bit seen", int'(tx_o), 0);
    chk(tx_ready_o, "R4", "ready high at start", int'(tx_ready_o), 1);
    for (int k = 0; k < 11; k++) begin
      cell_ok = 1;
      for (int s = 0; s < 16; s++) begin
        if (!(k == 0 && s == 0)) @(negedge clk);
        if (tx_o !== exp_bits[k]) cell_ok = 0;
      end
      if (k == 0)      chk(cell_ok, "R2", "start cell", int'(tx_o), 0);
      else if (k < 9)  chk(cell_ok, "R5", $sformatf("data bit %0d", k - 1),
                           int'(tx_o), int'(exp_bits[k]));
      else if (k == 9) chk(cell_ok, "R6", $sformatf("parity odd=%0d", odd),
                           int'(tx_o), int'(p));
      else             chk(cell_ok, "R7", "stop cell", int'(tx_o), 1);
    end
  endtask

  task automatic test_single(input logic [7:0] b, input bit odd);
    odd_par_i = odd;
    fork
      wr_byte(b);
      rx_frame(b, odd);
    join
  endtask

  task automatic test_idle();
    int bad = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!tx_o) bad++;
    end
    chk(bad == 0, "R7", "idle line high", bad, 0);
  endtask

  // R8: second byte written during first frame
  task automatic test_back_to_back(input logic [7:0] a, input logic [7:0] b,
                                   input bit odd);
    odd_par_i = odd;
    fork
      begin
        wr_byte(a);
        while (!tx_ready_o) @(negedge clk);
        repeat (5) @(negedge clk);
        wr_byte(b);
      end
      begin
        rx_frame(a, odd);
        @(negedge clk);
        chk(!tx_o, "R8", "next start right after stop", int'(tx_o), 0);
        rx_frame(b, odd);
      end
    join
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(tx_o === 1'b1, "R1", "tx during reset", int'(tx_o), 1);
    chk(tx_ready_o === 1'b1, "R1", "ready during reset", int'(tx_ready_o), 1);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    chk(tx_o === 1'b1, "R1", "tx after reset", int'(tx_o), 1);
    chk(tx_ready_o === 1'b1, "R1", "ready after reset", int'(tx_ready_o), 1);
    test_idle();
    test_single(8'hA5, 1'b0);
    test_single(8'h00, 1'b1);
    test_single(8'hFF, 1'b0);
    test_single(8'h80, 1'b1);
    test_single(8'h3C, 1'b1);
    test_single(8'h01, 1'b0);
    test_idle();
    test_back_to_back(8'h5A, 8'hC3, 1'b0);
    test_back_to_back(8'h7E, 8'h81, 1'b1);
    test_idle();
    summary();
  end
endmodule